// File: doc/BRIEF.md
# Capture Timer Channel with Ordered Register Pair

This block is one channel of a timer that measures signals instead of generating them. A free-running counter advances on every master-clock cycle in which the counting-clock enable is high. Two capture registers take a snapshot of the counter when chosen edges appear on input A. Capturing the start of a pulse into the first register and its end into the second gives pulse width, period or duty cycle as a difference of two snapshots. The two registers always fill in a fixed order: first register, then second, then first again. A trigger returns that order to its start and zeroes the counter.

A trigger can come from software, from a sync line, from an external compare-match strobe, or from a chosen edge of input A or input B. A trigger never acts at once. It waits for the next enabled counting edge. Both inputs pass through a synchronizer clocked by the master clock before any edge is decoded, so an input level must last longer than one master-clock period to be seen. A small read/write port gives access to the configuration, the two captured values and a status word. Reading that port clears the status bits as described below.

Top module: `cap_timer_chan`

## Requirements
- R1: On each clock with `cnt_en` high and no trigger due, the counter increments by one and wraps modulo 2^CNT_W. With `cnt_en` low it holds its value.
- R2: A software, sync or compare trigger pulse, or a decoded external trigger, zeroes the counter on the first clock edge with `cnt_en` high, at or after the pulse. While `cnt_en` stays low the trigger is kept pending and the counter holds.
- R3: Each capture register has a 2-bit edge selector: 0 = never, 1 = rising, 2 = falling, 3 = both edges of the synchronized input A. The selector for the first register is config bits [1:0], for the second bits [3:2]. A load stores the counter value two clocks after the input change, so a rise driven k clocks after a trigger edge captures k+2.
- R4: The first register loads only when no first-register load is outstanding, that is after a trigger or after the second register has loaded. The second register loads only after a first-register load that it has not yet followed. An applied trigger restores "first register next".
- R5: A load into a register whose loaded bit is still set raises the overrun flag and replaces the old value.
- R6: The address map is: 0 = config, 1 = first capture, 2 = second capture, 3 = status. Status bit 0 = first loaded, bit 1 = second loaded, bit 2 = overrun. Reading address 1 or 2 clears that register's loaded bit. Reading address 3 clears the overrun flag.
- R7: Config bit 6 picks the external trigger source: 0 = input A, 1 = input B. Config bits [5:4] pick its edge: 0 = none (disabled), 1 = rising, 2 = falling, 3 = both.
- R8: A write to address 0 stores `reg_wdata` as the configuration, and a read of address 0 returns it zero-extended. Reset clears the configuration, both captures and all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting-clock enable, one pulse per counting edge |
| in_a | input | 1 | External input A (capture source, optional trigger) |
| in_b | input | 1 | External input B (optional trigger) |
| sw_trig | input | 1 | Software trigger pulse |
| sync_trig | input | 1 | Sync trigger pulse shared between channels |
| cmp_trig | input | 1 | Compare-match trigger pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies the read side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 7 | Configuration write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` |

## Verification
The bench builds the channel with CNT_W = 8 and keeps the two synchronizer stages. With the narrower counter, wrap-around can be reached in a few hundred cycles: a capture taken 255 enabled cycles after a trigger must read back as a small value. The default 16-bit width would need tens of thousands of cycles for the same check. Every other behaviour is width-independent, so the narrower build loses nothing while keeping the expected capture values exact and small.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  typedef enum logic [1:0] {
    EDG_OFF  = 2'd0,
    EDG_RISE = 2'd1,
    EDG_FALL = 2'd2,
    EDG_BOTH = 2'd3
  } edge_sel_e;

  // bit 6: trigger source, [5:4] trigger edge, [3:2] second edge, [1:0] first edge
  typedef struct packed {
    logic      trg_src_b;
    edge_sel_e trg_edge;
    edge_sel_e b_edge;
    edge_sel_e a_edge;
  } cfg_t;

  localparam int CFG_W  = $bits(cfg_t);
  localparam int STAT_W = 3;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CAPA = 2'd1;
  localparam logic [1:0] ADDR_CAPB = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (sel)
      EDG_RISE: edge_hit = rise;
      EDG_FALL: edge_hit = fall;
      EDG_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cap_in_sync.sv
module cap_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dout_prev
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign dout      = stg_q[STAGES-1];
  assign dout_prev = prev_q;

endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         trig_evt,
  output logic [W-1:0] cnt,
  output logic         trig_apply
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         pend_q, pend_d;

  always_comb begin
    trig_apply = cnt_en & (pend_q | trig_evt);
    cnt_d      = cnt_q;
    pend_d     = pend_q;
    if (cnt_en) begin
      pend_d = 1'b0;
      if (trig_apply) cnt_d = '0;
      else            cnt_d = cnt_q + W'(1);
    end else if (trig_evt) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/cap_pair_ctrl.sv
module cap_pair_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         trig_apply,
  input  logic         hit_a,
  input  logic         hit_b,
  input  logic         rd_a,
  input  logic         rd_b,
  input  logic         rd_st,
  output logic [W-1:0] cap_a,
  output logic [W-1:0] cap_b,
  output logic         a_full,
  output logic         b_full,
  output logic         ovr,
  output logic         a_ld,
  output logic         b_ld,
  output logic         seq
);

  logic [W-1:0] cap_a_q, cap_a_d, cap_b_q, cap_b_d;
  logic         a_full_q, a_full_d, b_full_q, b_full_d;
  logic         ovr_q, ovr_d, seq_q, seq_d;
  logic         ovr_set;

  always_comb begin
    a_ld = hit_a & ~seq_q;
    b_ld = hit_b & seq_q;

    cap_a_d = a_ld ? cnt : cap_a_q;
    cap_b_d = b_ld ? cnt : cap_b_q;

    if (trig_apply) seq_d = 1'b0;
    else if (a_ld)  seq_d = 1'b1;
    else if (b_ld)  seq_d = 1'b0;
    else            seq_d = seq_q;

    if (a_ld)      a_full_d = 1'b1;
    else if (rd_a) a_full_d = 1'b0;
    else           a_full_d = a_full_q;

    if (b_ld)      b_full_d = 1'b1;
    else if (rd_b) b_full_d = 1'b0;
    else           b_full_d = b_full_q;

    ovr_set = (a_ld & a_full_q & ~rd_a) | (b_ld & b_full_q & ~rd_b);
    if (ovr_set)     ovr_d = 1'b1;
    else if (rd_st)  ovr_d = 1'b0;
    else             ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a_q  <= '0;
      cap_b_q  <= '0;
      a_full_q <= 1'b0;
      b_full_q <= 1'b0;
      ovr_q    <= 1'b0;
      seq_q    <= 1'b0;
    end else begin
      cap_a_q  <= cap_a_d;
      cap_b_q  <= cap_b_d;
      a_full_q <= a_full_d;
      b_full_q <= b_full_d;
      ovr_q    <= ovr_d;
      seq_q    <= seq_d;
    end
  end

  assign cap_a  = cap_a_q;
  assign cap_b  = cap_b_q;
  assign a_full = a_full_q;
  assign b_full = b_full_q;
  assign ovr    = ovr_q;
  assign seq    = seq_q;

endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             sw_trig,
  input  logic             sync_trig,
  input  logic             cmp_trig,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata
);

  localparam int CFG_PAD  = CNT_W - CFG_W;
  localparam int STAT_PAD = CNT_W - STAT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // configuration register
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (reg_wr && reg_addr == ADDR_CFG) cfg_d = cfg_t'(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= '0;
    else             cfg_q <= cfg_d;
  end

  // input synchronizers, bit 0 = A, bit 1 = B
  logic [1:0] in_s, in_p;

  cap_in_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .din       ({in_b, in_a}),
    .dout      (in_s),
    .dout_prev (in_p)
  );

  // edge decoding
  logic hit_a, hit_b, ext_evt, trig_evt;
  logic src_cur, src_prev;

  always_comb begin
    hit_a    = edge_hit(cfg_q.a_edge, in_s[0], in_p[0]);
    hit_b    = edge_hit(cfg_q.b_edge, in_s[0], in_p[0]);
    src_cur  = cfg_q.trg_src_b ? in_s[1] : in_s[0];
    src_prev = cfg_q.trg_src_b ? in_p[1] : in_p[0];
    ext_evt  = edge_hit(cfg_q.trg_edge, src_cur, src_prev);
    trig_evt = ext_evt | sw_trig | sync_trig | cmp_trig;
  end

  // counter
  logic [CNT_W-1:0] cnt_w;
  logic             trig_apply;

  cap_counter #(.W(CNT_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_en     (cnt_en),
    .trig_evt   (trig_evt),
    .cnt        (cnt_w),
    .trig_apply (trig_apply)
  );

  // capture pair
  logic             rd_a, rd_b, rd_st;
  logic [CNT_W-1:0] cap_a, cap_b;
  logic             a_full, b_full, ovr, a_ld, b_ld, seq;

  assign rd_a  = reg_rd && (reg_addr == ADDR_CAPA);
  assign rd_b  = reg_rd && (reg_addr == ADDR_CAPB);
  assign rd_st = reg_rd && (reg_addr == ADDR_STAT);

  cap_pair_ctrl #(.W(CNT_W)) i_pair (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt        (cnt_w),
    .trig_apply (trig_apply),
    .hit_a      (hit_a),
    .hit_b      (hit_b),
    .rd_a       (rd_a),
    .rd_b       (rd_b),
    .rd_st      (rd_st),
    .cap_a      (cap_a),
    .cap_b      (cap_b),
    .a_full     (a_full),
    .b_full     (b_full),
    .ovr        (ovr),
    .a_ld       (a_ld),
    .b_ld       (b_ld),
    .seq        (seq)
  );

  // read mux
  always_comb begin
    case (reg_addr)
      ADDR_CFG:  reg_rdata = {{CFG_PAD{1'b0}}, cfg_q};
      ADDR_CAPA: reg_rdata = cap_a;
      ADDR_CAPB: reg_rdata = cap_b;
      default:   reg_rdata = {{STAT_PAD{1'b0}}, ovr, b_full, a_full};
    endcase
  end

endmodule

// File: rtl/cap_timer_chan_chk.sv
module cap_timer_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic [W-1:0] cnt,
  input logic         apply,
  input logic         a_ld,
  input logic         b_ld,
  input logic         seq,
  input logic         ovr,
  input logic         rd_st
);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !apply) |=> (cnt == W'($past(cnt) + W'(1))));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (cnt == '0));

  p_a_then_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ld && !apply) |=> seq);

  p_b_then_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_ld |=> !seq);

  p_single_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ld && b_ld));

  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rd_st) |=> ovr);

endmodule

bind cap_timer_chan cap_timer_chan_chk #(.W(CNT_W)) i_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .cnt_en (cnt_en),
  .cnt    (cnt_w),
  .apply  (trig_apply),
  .a_ld   (a_ld),
  .b_ld   (b_ld),
  .seq    (seq),
  .ovr    (ovr),
  .rd_st  (rd_st)
);

// File: tb/test_cap_timer_chan.sv
module test_cap_timer_chan;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cnt_en, in_a, in_b, sw_trig, sync_trig, cmp_trig;
  logic         reg_wr, reg_rd;
  logic [1:0]   reg_addr;
  logic [6:0]   reg_wdata;
  logic [W-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  cap_timer_chan #(.CNT_W(W), .SYNC_STAGES(2)) i_cap_timer_chan (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .in_a      (in_a),
    .in_b      (in_b),
    .sw_trig   (sw_trig),
    .sync_trig (sync_trig),
    .cmp_trig  (cmp_trig),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  always #4 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    step();
    reg_addr = a;
    reg_rd   = 1'b1;
    #1 v = reg_rdata;
    step();
    reg_rd = 1'b0;
  endtask

  task automatic wr_cfg(input logic [6:0] v);
    step();
    reg_addr  = 2'd0;
    reg_wdata = v;
    reg_wr    = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  // 0 = software, 1 = sync, 2 = compare; returns just after the applying edge
  task automatic trig(input int which);
    step();
    case (which)
      1:       sync_trig = 1'b1;
      2:       cmp_trig  = 1'b1;
      default: sw_trig   = 1'b1;
    endcase
    step();
    sw_trig = 1'b0; sync_trig = 1'b0; cmp_trig = 1'b0;
  endtask

  task automatic clear_all(output logic [W-1:0] bval);
    logic [W-1:0] v;
    trig(0);
    repeat (4) step();
    rd(2'd3, v);
    rd(2'd1, v);
    rd(2'd2, bval);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(2'd0, v); chk("R8 reset config", v, 0);
    rd(2'd3, v); chk("R6 reset status", v, 0);
    rd(2'd1, v); chk("R8 reset capture A", v, 0);
    rd(2'd2, v); chk("R8 reset capture B", v, 0);
  endtask

  task automatic t_cfg();
    logic [W-1:0] v;
    wr_cfg(7'h5A);
    rd(2'd0, v); chk("R8 config readback", v, 8'h5A);
  endtask

  task automatic t_pulse();
    logic [W-1:0] v, bv;
    wr_cfg(7'h09);
    clear_all(bv);
    trig(1);
    in_a = 1'b1;
    repeat (7) step();
    in_a = 1'b0;
    repeat (4) step();
    rd(2'd3, v); chk("R6 both loaded status", v, 3);
    rd(2'd1, v); chk("R3 rise capture value (sync trigger R2)", v, 2);
    rd(2'd2, v); chk("R3 fall capture value", v, 9);
    rd(2'd3, v); chk("R6 reads clear loaded bits", v, 0);
  endtask

  task automatic t_both();
    logic [W-1:0] v, bv;
    wr_cfg(7'h0F);
    clear_all(bv);
    trig(2);
    in_a = 1'b1;
    repeat (3) step();
    in_a = 1'b0;
    repeat (4) step();
    rd(2'd1, v); chk("R3 both-edge first capture (compare trigger R2)", v, 2);
    rd(2'd2, v); chk("R3 both-edge second capture", v, 5);
  endtask

  task automatic t_order();
    logic [W-1:0] v, bv;
    wr_cfg(7'h05);
    clear_all(bv);
    trig(0);
    in_a = 1'b1; repeat (2) step();
    in_a = 1'b0; repeat (2) step();
    in_a = 1'b1; repeat (2) step();
    in_a = 1'b0; repeat (2) step();
    in_a = 1'b1; repeat (2) step();
    in_a = 1'b0; repeat (4) step();
    rd(2'd3, v); chk("R4 alternation status with overrun", v, 7);
    rd(2'd1, v); chk("R4 third rise goes to A", v, 10);
    rd(2'd2, v); chk("R4 second rise goes to B", v, 6);
  endtask

  task automatic t_need_a();
    logic [W-1:0] v, bv;
    wr_cfg(7'h04);
    clear_all(bv);
    in_a = 1'b1; repeat (3) step();
    in_a = 1'b0; repeat (3) step();
    in_a = 1'b1; repeat (3) step();
    in_a = 1'b0; repeat (4) step();
    rd(2'd3, v); chk("R4 B never loads without A (R3 edge off)", v, 0);
    rd(2'd2, v); chk("R4 B value untouched", v, bv);
  endtask

  task automatic t_reorder();
    logic [W-1:0] v, bv;
    wr_cfg(7'h09);
    clear_all(bv);
    in_a = 1'b1; repeat (4) step();
    trig(0);
    in_a = 1'b0; repeat (4) step();
    in_a = 1'b1; repeat (4) step();
    rd(2'd3, v); chk("R4 trigger restarts order, A reloads", v, 5);
    rd(2'd2, v); chk("R4 B not loaded after trigger", v, bv);
    in_a = 1'b0; repeat (4) step();
  endtask

  task automatic t_overrun();
    logic [W-1:0] v, bv;
    wr_cfg(7'h09);
    clear_all(bv);
    trig(0);
    in_a = 1'b1; repeat (3) step();
    in_a = 1'b0; repeat (3) step();
    in_a = 1'b1; repeat (3) step();
    in_a = 1'b0; repeat (4) step();
    rd(2'd3, v); chk("R5 overrun raised", v, 7);
    rd(2'd3, v); chk("R6 status read clears overrun only", v, 3);
    rd(2'd1, v); chk("R5 A overwritten", v, 8);
    rd(2'd2, v); chk("R5 B overwritten", v, 11);
  endtask

  task automatic t_hold();
    logic [W-1:0] v, bv, frozen;
    wr_cfg(7'h09);
    clear_all(bv);
    step(); cnt_en = 1'b0;
    in_a = 1'b1; repeat (4) step();
    rd(2'd1, frozen);
    in_a = 1'b0; repeat (4) step();
    rd(2'd2, v); chk("R1 counter holds without enable", v, frozen);
    trig(1);
    in_a = 1'b1; repeat (4) step();
    rd(2'd1, v); chk("R2 trigger deferred while disabled", v, frozen);
    in_a = 1'b0; repeat (4) step();
    rd(2'd2, v);
    step(); cnt_en = 1'b1;
    step(); cnt_en = 1'b0;
    in_a = 1'b1; repeat (4) step();
    rd(2'd1, v); chk("R2 pending trigger applied on enabled edge", v, 0);
    in_a = 1'b0; repeat (4) step();
    cnt_en = 1'b1;
    rd(2'd2, v);
  endtask

  task automatic t_ext();
    logic [W-1:0] v, bv;
    wr_cfg(7'h59);
    clear_all(bv);
    step();
    in_b = 1'b1;
    repeat (5) step();
    in_a = 1'b1;
    in_b = 1'b0;
    repeat (3) step();
    in_a = 1'b0;
    repeat (4) step();
    rd(2'd1, v); chk("R7 input B rise resets counter", v, 4);
    rd(2'd2, v); chk("R7 capture after external trigger", v, 7);
    wr_cfg(7'h49);
    clear_all(bv);
    trig(0);
    in_b = 1'b1;
    repeat (5) step();
    in_a = 1'b1;
    repeat (4) step();
    rd(2'd1, v); chk("R7 edge none disables external trigger", v, 7);
    in_a = 1'b0; in_b = 1'b0;
    repeat (4) step();
    rd(2'd2, v);
  endtask

  task automatic t_wrap();
    logic [W-1:0] v, bv;
    wr_cfg(7'h09);
    clear_all(bv);
    trig(0);
    repeat (255) step();
    in_a = 1'b1; repeat (2) step();
    in_a = 1'b0; repeat (4) step();
    rd(2'd1, v); chk("R1 counter wraps", v, 1);
    rd(2'd2, v); chk("R1 counting continues after wrap", v, 3);
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b1; in_a = 1'b0; in_b = 1'b0;
    sw_trig = 1'b0; sync_trig = 1'b0; cmp_trig = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_cfg();
    t_pulse();
    t_both();
    t_order();
    t_need_a();
    t_reorder();
    t_overrun();
    t_hold();
    t_ext();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule